// File: doc/BRIEF.md
# Self-Timed Fall-Through Stack

This block is a first-in first-out store built as a column of storage locations. Each location holds one word and a flag that says whether the word is present. A new word is written into the highest location. It then moves down one location per clock and stops only when the location under it holds a word. The lowest location, location 0, is the read side. A reader sees its flag and its data, and a pop strobe removes that word.

No read or write pointers exist. The order of the words is kept by their physical position in the column. Every location can pass its word down in the same cycle that the location under it gives up its own word. Because of this, a completely full column can be drained at one word per clock. A master reset clears every presence flag. It does not clear the data bits, so the word at location 0 stays visible on the data output after reset, flagged as not valid.

By default the column is 62 locations deep and 4 bits wide. Both values are parameters.

Top module: `fall_through_stack`

## Requirements
- R1: While `rst` is high, all presence flags are cleared. After release, `top_empty` reads 1 and `bottom_valid` reads 0.
- R2: Reset leaves the data bits unchanged. `bottom_data` shows the same value before and after a reset.
- R3: `push` is taken on a rising edge only if `top_empty` was 1 before that edge. An accepted word sits in the highest location for exactly one cycle, so `top_empty` reads 0 in the cycle after it.
- R4: A word moves down at most one location per clock and stops above an occupied location. In an empty column, `bottom_valid` rises exactly DEPTH rising edges after the push, counting the edge that captures the push.
- R5: Words leave at location 0 in the order in which they were pushed, with no loss and no duplication.
- R6: After DEPTH pushes with no pop, the column is full and `top_empty` stays 0. A further push is ignored, and draining returns exactly DEPTH words.
- R7: A pop on a rising edge with `bottom_valid` high removes the bottom word. A pop with `bottom_valid` low has no effect, and a word already moving down still arrives unchanged.
- R8: A location may take a word from the location above it in the same cycle that it gives up its own word. So a full column popped on every clock keeps `bottom_valid` high for DEPTH consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Master reset, asynchronous, active high; clears presence flags only |
| push | input | 1 | Write strobe, taken when `top_empty` is high |
| push_data | input | WIDTH | Word to be written into the highest location |
| top_empty | output | 1 | Highest location is free |
| pop | input | 1 | Remove the word at location 0 |
| bottom_valid | output | 1 | Location 0 holds a word |
| bottom_data | output | WIDTH | Data bits of location 0 |

## Verification
The assertions assume that `push` and `pop` are sampled only on rising edges. They also assume that the flag-count check holds only across cycles in which reset was low. A pop or push that the column cannot honour is treated as a legal input that must be ignored, not as a protocol error. The stimulus changes every input on the falling clock edge. The write task waits for `top_empty` before it raises `push`, except in one deliberate overflow attempt on a full column. The read side is driven either by the monitor, which pops only when `bottom_valid` is high, or by a separate forced-pop line that is held high on an empty column to show that such pops are ignored.

// File: rtl/fall_through_stack.sv
module fall_through_stack #(
  parameter int DEPTH = 62,
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  output logic             top_empty,
  input  logic             pop,
  output logic             bottom_valid,
  output logic [WIDTH-1:0] bottom_data
);
  localparam int TOP = DEPTH - 1;

  logic [DEPTH-1:0] occ;
  logic [DEPTH-1:0] vacate;
  logic [DEPTH-1:0] fill;
  logic [WIDTH-1:0] word [DEPTH];

  always_comb begin
    vacate[0] = pop & occ[0];
    for (int i = 1; i < DEPTH; i++)
      vacate[i] = occ[i] & (~occ[i-1] | vacate[i-1]);
  end

  always_comb begin
    for (int i = 0; i < TOP; i++)
      fill[i] = vacate[i+1];
    fill[TOP] = push & ~occ[TOP];
  end

  always_ff @(posedge clk or posedge rst)
    if (rst) occ <= '0;
    else     occ <= (occ & ~vacate) | fill;

  always_ff @(posedge clk) begin
    for (int i = 0; i < TOP; i++)
      if (fill[i]) word[i] <= word[i+1];
    if (fill[TOP]) word[TOP] <= push_data;
  end

  assign top_empty    = ~occ[TOP];
  assign bottom_valid = occ[0];
  assign bottom_data  = word[0];
endmodule

// File: rtl/fall_through_stack_chk.sv
module fall_through_stack_chk #(
  parameter int DEPTH = 62
) (
  input logic             clk,
  input logic             rst,
  input logic             push,
  input logic             pop,
  input logic             top_empty,
  input logic             bottom_valid,
  input logic [DEPTH-1:0] occ
);
  always @(posedge clk)
    if (rst) a_r1_flags_cleared: assert (occ == '0);

  a_r3_push_lands: assert property (@(posedge clk) disable iff (rst)
    top_empty && push |=> !top_empty);

  a_r5_count_kept: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $countones(occ) == $countones($past(occ))
      + int'($past(push && top_empty)) - int'($past(pop && bottom_valid)));

  a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
    !top_empty && push && !pop |=> $countones(occ) == $past($countones(occ)));

  a_r7_idle_pop: assert property (@(posedge clk) disable iff (rst)
    !bottom_valid && pop && !occ[1] |=> !bottom_valid);

  a_r8_refill: assert property (@(posedge clk) disable iff (rst)
    bottom_valid && pop && occ[1] |=> bottom_valid);
endmodule

bind fall_through_stack fall_through_stack_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .push(push), .pop(pop),
  .top_empty(top_empty), .bottom_valid(bottom_valid), .occ(occ)
);

// File: tb/tb_fall_through_stack.sv
module tb_fall_through_stack;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 62;
  localparam int WIDTH = 4;

  logic clk = 0;
  logic rst = 1;
  logic push = 0;
  logic [WIDTH-1:0] push_data = '0;
  logic top_empty, bottom_valid;
  logic [WIDTH-1:0] bottom_data;
  logic mon_pop = 0, force_pop = 0, pop_en = 0;
  logic pop;
  assign pop = mon_pop | force_pop;

  int n_checks = 0, n_fail = 0, popped = 0;
  logic [WIDTH-1:0] q [$];

  fall_through_stack #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dut (
    .clk(clk), .rst(rst), .push(push), .push_data(push_data),
    .top_empty(top_empty), .pop(pop),
    .bottom_valid(bottom_valid), .bottom_data(bottom_data));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  task automatic push_word(input logic [WIDTH-1:0] d);
    @(negedge clk);
    while (!top_empty) @(negedge clk);
    q.push_back(d);
    push = 1; push_data = d;
    @(negedge clk);
    push = 0;
    check(top_empty == 0, "R3", int'(top_empty), 0);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (pop_en && bottom_valid) begin
        if (q.size() == 0) check(0, "R5", int'(bottom_data), -1);
        else begin
          logic [WIDTH-1:0] e;
          e = q.pop_front();
          check(bottom_data == e, "R5", int'(bottom_data), int'(e));
        end
        popped++;
        mon_pop = 1;
      end else mon_pop = 0;
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin : stimulus
    int lat;
    logic [WIDTH-1:0] a;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(top_empty == 1, "R1", int'(top_empty), 1);
    check(bottom_valid == 0, "R1", int'(bottom_valid), 0);

    // R4 latency, R7 pops on an empty column are ignored
    a = 4'hA;
    push = 1; push_data = a; force_pop = 1;
    @(posedge clk); lat = 1;
    @(negedge clk); push = 0;
    while (!bottom_valid && lat < 300) begin
      if (lat == 12) force_pop = 0;
      @(posedge clk); lat++;
      @(negedge clk);
    end
    force_pop = 0;
    check(lat == DEPTH, "R4", lat, DEPTH);
    check(bottom_data == a, "R7", int'(bottom_data), int'(a));

    // R2 reset keeps data, R1 clears flags
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(bottom_valid == 0, "R1", int'(bottom_valid), 0);
    check(top_empty == 1, "R1", int'(top_empty), 1);
    check(bottom_data == a, "R2", int'(bottom_data), int'(a));

    // R6 fill to full without pops
    for (int i = 0; i < DEPTH; i++) push_word(WIDTH'(i * 5 + 3));
    repeat (DEPTH + 4) @(negedge clk);
    check(top_empty == 0, "R6", int'(top_empty), 0);
    check(bottom_valid == 1, "R6", int'(bottom_valid), 1);
    push = 1; push_data = 4'hF;
    @(negedge clk);
    push = 0;
    check(top_empty == 0, "R6", int'(top_empty), 0);

    // R8 back-to-back drain
    popped = 0;
    @(posedge clk); pop_en = 1;
    for (int k = 0; k < DEPTH; k++) begin
      @(negedge clk);
      check(bottom_valid == 1, "R8", int'(bottom_valid), 1);
    end
    @(negedge clk);
    check(bottom_valid == 0, "R6", int'(bottom_valid), 0);
    check(popped == DEPTH, "R6", popped, DEPTH);
    check(q.size() == 0, "R6", q.size(), 0);

    // R5 ordering with concurrent reads
    for (int i = 0; i < 100; i++) push_word(WIDTH'((i * 7) ^ (i >> 2)));
    repeat (2 * DEPTH + 10) @(negedge clk);
    check(q.size() == 0, "R5", q.size(), 0);
    check(bottom_valid == 0, "R5", int'(bottom_valid), 0);
    check(top_empty == 1, "R3", int'(top_empty), 1);

    finish_run();
  end
endmodule